// File: doc/BRIEF.md
# Transfer Descriptor Executor

This block runs a single transfer descriptor for a frame-list scheduler in a serial-bus host controller. The scheduler hands it the descriptor's control/status word, its token word and its buffer address with a one-cycle start strobe. The block splits the token into packet identifier, device address, endpoint and maximum length. It then checks the descriptor, issues one transaction request to the device side and waits for that side's handshake.

When the handshake arrives, or at once when the descriptor is inactive or malformed, the block returns a single-cycle result. The result carries one of four outcome codes, the rewritten control/status word for the scheduler to store back, a two-bit interrupt-cause vector and, for malformed descriptors, a process-error pulse. Payload movement happens elsewhere. Only byte counts cross this interface.

Top module: `td_executor`

## Requirements
- R1: After a start, the request presents the packet identifier from token bits [7:0], the device address from bits [14:8], the endpoint from bits [18:15], the data toggle from bit 19 and the buffer address unchanged, with `dev_req` high for exactly one cycle.
- R2: The maximum length on `dev_len` is token bits [31:21] plus one, kept to 11 bits, so a field of 0x7FF gives 0.
- R3: When control bit 24 (interrupt on completion) is set, every result carries `res_int[0]` = 1, including results for inactive descriptors.
- R4: When control bit 23 (active) is clear, no request is issued and the result is code 1 (stopped) with the control word unchanged. This check takes precedence over the identifier check.
- R5: An active descriptor whose identifier is not 0x2D (SETUP), 0xE1 (OUT) or 0x69 (IN) gives code 3 (fatal), a one-cycle `res_perr`, no request and an unchanged control word.
- R6: An accepted handshake (response code 0) gives code 0. Control bits [10:0] become (length − 1) mod 2048, and bits 23 and 19 (NAK) are cleared. The length is the maximum length for SETUP and OUT, and the returned length for IN.
- R7: An IN that returns more bytes than the maximum length has its length clamped to the maximum. Bit 20 (babble) and bit 22 (stalled) are set, active is cleared and the result is code 1.
- R8: `res_int[1]` is raised only for a successful IN with control bit 29 (short-packet detect) set and a length below the maximum.
- R9: A deferred handshake (response code 4) gives code 2 (pending) with the control word unchanged.
- R10: A NAK handshake (code 1) sets bit 19 and keeps active set. A stall handshake (code 2) sets bit 22 and clears active. Both give result code 1.
- R11: An error handshake (code 3 or any undefined code) sets bit 18 and decrements the error counter in bits [28:27] if it is non-zero. Active is cleared when the counter reaches 0. A counter already at 0 stays 0 and active stays set. The result is code 1.
- R12: With control bit 25 (isochronous) set, active is cleared after any handshake except a deferred one.
- R13: After reset, `res_valid`, `dev_req` and `res_perr` are low. A start strobe while a descriptor is in flight is ignored, and each descriptor yields exactly one `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| td_start | input | 1 | Start strobe for a new descriptor |
| td_ctrl | input | 32 | Descriptor control/status word |
| td_token | input | 32 | Descriptor token word |
| td_buf | input | ADDR_W | Descriptor buffer address |
| dev_req | output | 1 | One-cycle transaction request to the device side |
| dev_pid | output | 8 | Packet identifier of the request |
| dev_addr | output | 7 | Target device address |
| dev_ep | output | 4 | Target endpoint |
| dev_toggle | output | 1 | Data toggle for the request |
| dev_len | output | 11 | Maximum transfer length |
| dev_buf | output | ADDR_W | Buffer address for the payload mover |
| dev_rsp_valid | input | 1 | Handshake strobe from the device side |
| dev_rsp_code | input | 3 | 0 ack, 1 NAK, 2 stall, 3 error, 4 deferred |
| dev_rsp_len | input | RSP_LEN_W | Byte count returned for an IN |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 success, 1 stopped, 2 pending, 3 fatal |
| res_ctrl | output | 32 | Rewritten control/status word |
| res_int | output | 2 | Interrupt causes: bit 0 completion, bit 1 short packet |
| res_perr | output | 1 | Process-error pulse for a malformed identifier |

## Verification
The bench builds the block with its default parameters: an 11-bit length field, a 12-bit returned length and a 32-bit address. The wider returned length allows an IN reply that exceeds any maximum, which drives the babble path. The all-ones length field makes the plus-one wrap to zero reachable, and a zero-byte IN reply makes the minus-one wrap of the actual-length field reachable. A delayed handshake keeps the block busy long enough to show that a second start strobe is dropped.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 11;
  localparam int ERR_W    = 2;
  // control/status bit positions
  localparam int B_ACTIVE = 23;
  localparam int B_STALL  = 22;
  localparam int B_BABBLE = 20;
  localparam int B_NAK    = 19;
  localparam int B_TMO    = 18;
  localparam int B_IOC    = 24;
  localparam int B_ISO    = 25;
  localparam int B_SPD    = 29;
  localparam int ERR_LO   = 27;
  // token field positions
  localparam int T_ADDR_LO = 8;
  localparam int T_EP_LO   = 15;
  localparam int T_TOG     = 19;
  localparam int T_LEN_LO  = 21;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_STOP  = 2'd1,
    RES_PEND  = 2'd2,
    RES_FATAL = 2'd3
  } td_res_e;

  typedef enum logic [2:0] {
    RSP_ACK   = 3'd0,
    RSP_NAK   = 3'd1,
    RSP_STALL = 3'd2,
    RSP_ERR   = 3'd3,
    RSP_DEFER = 3'd4
  } dev_rsp_e;

  typedef struct packed {
    logic [7:0]       pid;
    logic [6:0]       dev;
    logic [3:0]       ep;
    logic             tog;
    logic [LEN_W-1:0] maxlen;
    logic             pid_ok;
    logic             is_in;
  } tok_s;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_pkg::*;
(
  input  logic [WORD_W-1:0] token,
  output tok_s              dec
);
  logic rsvd_unused;
  assign rsvd_unused = token[T_TOG+1];

  always_comb begin
    dec.pid    = token[7:0];
    dec.dev    = token[T_ADDR_LO +: 7];
    dec.ep     = token[T_EP_LO +: 4];
    dec.tog    = token[T_TOG];
    dec.maxlen = token[T_LEN_LO +: LEN_W] + LEN_W'(1);
    dec.is_in  = (token[7:0] == PID_IN);
    dec.pid_ok = (token[7:0] == PID_IN) || (token[7:0] == PID_OUT) ||
                 (token[7:0] == PID_SETUP);
  end
endmodule

// File: rtl/td_status_update.sv
module td_status_update
  import td_pkg::*;
#(
  parameter int RSP_LEN_W = 12
) (
  input  logic [WORD_W-1:0]    ctrl,
  input  logic                 is_in,
  input  logic [LEN_W-1:0]     maxlen,
  input  logic [2:0]           rsp_code,
  input  logic [RSP_LEN_W-1:0] rsp_len,
  output logic [WORD_W-1:0]    new_ctrl,
  output td_res_e              res,
  output logic                 short_pkt
);
  localparam int PAD_W = RSP_LEN_W - LEN_W;

  logic             over;
  logic [LEN_W-1:0] act_len;
  logic [ERR_W-1:0] err_cnt;

  assign over    = is_in && (rsp_len > {{PAD_W{1'b0}}, maxlen});
  assign act_len = (is_in && !over) ? rsp_len[LEN_W-1:0] : maxlen;
  assign err_cnt = ctrl[ERR_LO +: ERR_W];

  always_comb begin
    new_ctrl  = ctrl;
    res       = RES_STOP;
    short_pkt = 1'b0;
    case (rsp_code)
      RSP_DEFER: res = RES_PEND;
      RSP_ACK: begin
        new_ctrl[LEN_W-1:0] = act_len - LEN_W'(1);
        new_ctrl[B_ACTIVE]  = 1'b0;
        if (over) begin
          new_ctrl[B_BABBLE] = 1'b1;
          new_ctrl[B_STALL]  = 1'b1;
        end else begin
          new_ctrl[B_NAK] = 1'b0;
          res             = RES_OK;
          short_pkt       = is_in && ctrl[B_SPD] && (act_len < maxlen);
        end
      end
      RSP_NAK: new_ctrl[B_NAK] = 1'b1;
      RSP_STALL: begin
        new_ctrl[B_STALL]  = 1'b1;
        new_ctrl[B_ACTIVE] = 1'b0;
      end
      default: begin
        new_ctrl[B_TMO] = 1'b1;
        if (err_cnt != '0) begin
          new_ctrl[ERR_LO +: ERR_W] = err_cnt - ERR_W'(1);
          if (err_cnt == ERR_W'(1)) new_ctrl[B_ACTIVE] = 1'b0;
        end
      end
    endcase
    if (ctrl[B_ISO] && (rsp_code != RSP_DEFER)) new_ctrl[B_ACTIVE] = 1'b0;
  end
endmodule

// File: rtl/td_executor.sv
module td_executor
  import td_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RSP_LEN_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 td_start,
  input  logic [WORD_W-1:0]    td_ctrl,
  input  logic [WORD_W-1:0]    td_token,
  input  logic [ADDR_W-1:0]    td_buf,
  output logic                 dev_req,
  output logic [7:0]           dev_pid,
  output logic [6:0]           dev_addr,
  output logic [3:0]           dev_ep,
  output logic                 dev_toggle,
  output logic [LEN_W-1:0]     dev_len,
  output logic [ADDR_W-1:0]    dev_buf,
  input  logic                 dev_rsp_valid,
  input  logic [2:0]           dev_rsp_code,
  input  logic [RSP_LEN_W-1:0] dev_rsp_len,
  output logic                 res_valid,
  output logic [1:0]           res_code,
  output logic [WORD_W-1:0]    res_ctrl,
  output logic [1:0]           res_int,
  output logic                 res_perr
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT} st_e;

  st_e               st;
  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] tok_q;
  logic [ADDR_W-1:0] buf_q;
  tok_s              dec;
  logic [WORD_W-1:0] upd_ctrl;
  td_res_e           upd_res;
  logic              upd_short;

  td_token_decode u_dec (
    .token (tok_q),
    .dec   (dec)
  );

  td_status_update #(.RSP_LEN_W(RSP_LEN_W)) u_upd (
    .ctrl      (ctrl_q),
    .is_in     (dec.is_in),
    .maxlen    (dec.maxlen),
    .rsp_code  (dev_rsp_code),
    .rsp_len   (dev_rsp_len),
    .new_ctrl  (upd_ctrl),
    .res       (upd_res),
    .short_pkt (upd_short)
  );

  assign dev_pid    = dec.pid;
  assign dev_addr   = dec.dev;
  assign dev_ep     = dec.ep;
  assign dev_toggle = dec.tog;
  assign dev_len    = dec.maxlen;
  assign dev_buf    = buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ctrl_q    <= '0;
      tok_q     <= '0;
      buf_q     <= '0;
      dev_req   <= 1'b0;
      res_valid <= 1'b0;
      res_code  <= RES_OK;
      res_ctrl  <= '0;
      res_int   <= '0;
      res_perr  <= 1'b0;
    end else begin
      dev_req   <= 1'b0;
      res_valid <= 1'b0;
      res_perr  <= 1'b0;
      case (st)
        ST_IDLE: if (td_start) begin
          ctrl_q <= td_ctrl;
          tok_q  <= td_token;
          buf_q  <= td_buf;
          st     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!ctrl_q[B_ACTIVE] || !dec.pid_ok) begin
            res_valid <= 1'b1;
            res_ctrl  <= ctrl_q;
            res_int   <= {1'b0, ctrl_q[B_IOC]};
            res_code  <= ctrl_q[B_ACTIVE] ? RES_FATAL : RES_STOP;
            res_perr  <= ctrl_q[B_ACTIVE];
            st        <= ST_IDLE;
          end else begin
            dev_req <= 1'b1;
            st      <= ST_WAIT;
          end
        end
        ST_WAIT: if (dev_rsp_valid) begin
          res_valid <= 1'b1;
          res_code  <= upd_res;
          res_ctrl  <= upd_ctrl;
          res_int   <= {upd_short, ctrl_q[B_IOC]};
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_req_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    dev_req |=> !dev_req);
  p_ioc_cause_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_int[0] == ctrl_q[B_IOC]));
  p_no_req_inactive_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && !ctrl_q[B_ACTIVE]) |=> (!dev_req && res_valid));
  p_fatal_perr_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_FATAL) |-> res_perr);
  p_success_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_OK) |-> (!res_ctrl[B_ACTIVE] && !res_ctrl[B_NAK]));
  p_pending_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_PEND) |-> (res_ctrl == ctrl_q));
  p_result_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

// File: tb/td_executor_test.sv
`timescale 1ns/1ps
module td_executor_test;
  localparam logic [31:0] A   = 32'h0080_0000;
  localparam logic [31:0] IOC = 32'h0100_0000;
  localparam logic [31:0] ISO = 32'h0200_0000;
  localparam logic [31:0] SPD = 32'h2000_0000;
  localparam logic [31:0] NAK = 32'h0008_0000;
  localparam logic [31:0] STL = 32'h0040_0000;
  localparam logic [31:0] BAB = 32'h0010_0000;
  localparam logic [31:0] TMO = 32'h0004_0000;
  localparam logic [31:0] E1C = 32'h0800_0000;
  localparam logic [31:0] E2C = 32'h1000_0000;
  localparam logic [31:0] E3C = 32'h1800_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic td_start = 1'b0;
  logic [31:0] td_ctrl = '0, td_token = '0, td_buf = '0;
  logic dev_req, dev_toggle;
  logic [7:0] dev_pid;
  logic [6:0] dev_addr;
  logic [3:0] dev_ep;
  logic [10:0] dev_len;
  logic [31:0] dev_buf;
  logic dev_rsp_valid = 1'b0;
  logic [2:0] dev_rsp_code = '0;
  logic [11:0] dev_rsp_len = '0;
  logic res_valid, res_perr;
  logic [1:0] res_code, res_int;
  logic [31:0] res_ctrl;

  int n_checks = 0;
  int n_fail = 0;

  // captured per descriptor
  bit saw_req, saw_perr;
  int npulse;
  logic [1:0] c_code, c_int;
  logic [31:0] c_ctrl, c_buf;
  logic [7:0] c_pid;
  logic [6:0] c_addr;
  logic [3:0] c_ep;
  logic c_tog;
  logic [10:0] c_len;

  always #2.5 clk = ~clk;

  td_executor uut (
    .clk(clk), .rst(rst), .td_start(td_start), .td_ctrl(td_ctrl),
    .td_token(td_token), .td_buf(td_buf), .dev_req(dev_req),
    .dev_pid(dev_pid), .dev_addr(dev_addr), .dev_ep(dev_ep),
    .dev_toggle(dev_toggle), .dev_len(dev_len), .dev_buf(dev_buf),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_code(dev_rsp_code),
    .dev_rsp_len(dev_rsp_len), .res_valid(res_valid), .res_code(res_code),
    .res_ctrl(res_ctrl), .res_int(res_int), .res_perr(res_perr)
  );

  function automatic logic [31:0] mk_tok(input logic [10:0] mf, input logic tog,
      input logic [3:0] ep, input logic [6:0] ad, input logic [7:0] pid);
    return {mf, 1'b0, tog, ep, ad, pid};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [31:0] c, input logic [31:0] t, input logic [31:0] b,
      input logic [2:0] rc, input logic [11:0] rl, input int dly, input bit poke);
    int wait_n;
    wait_n = -1;
    saw_req = 0; saw_perr = 0; npulse = 0;
    c_code = 'x; c_ctrl = 'x; c_int = 'x;
    @(negedge clk);
    td_start = 1'b1; td_ctrl = c; td_token = t; td_buf = b;
    @(negedge clk);
    td_start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (dev_req) begin
        saw_req = 1; wait_n = dly;
        c_pid = dev_pid; c_addr = dev_addr; c_ep = dev_ep;
        c_tog = dev_toggle; c_len = dev_len; c_buf = dev_buf;
      end
      dev_rsp_valid = 1'b0;
      if (wait_n == 0) begin
        dev_rsp_valid = 1'b1; dev_rsp_code = rc; dev_rsp_len = rl;
      end
      if (wait_n >= 0) wait_n--;
      if (poke && i == 1) begin
        td_start = 1'b1; td_ctrl = 32'hFFFF_FFFF; td_token = 32'h0;
      end else td_start = 1'b0;
      if (res_valid) begin
        if (npulse == 0) begin
          c_code = res_code; c_ctrl = res_ctrl; c_int = res_int; saw_perr = res_perr;
        end
        npulse++;
      end
      @(negedge clk);
    end
    dev_rsp_valid = 1'b0;
    td_start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R13 reset res_valid", {31'b0, res_valid}, 32'd0);
    chk("R13 reset dev_req", {31'b0, dev_req}, 32'd0);
    chk("R13 reset res_perr", {31'b0, res_perr}, 32'd0);
  endtask

  task automatic t_out_ok;
    exec(IOC | A | NAK | E3C | 32'h123, mk_tok(11'd7, 1'b1, 4'hA, 7'h55, 8'hE1),
         32'hCAFE_0040, 3'd0, 12'd0, 0, 0);
    chk("R1 request seen", {31'b0, saw_req}, 32'd1);
    chk("R1 pid", {24'b0, c_pid}, 32'hE1);
    chk("R1 addr", {25'b0, c_addr}, 32'h55);
    chk("R1 ep", {28'b0, c_ep}, 32'hA);
    chk("R1 toggle", {31'b0, c_tog}, 32'd1);
    chk("R1 buffer", c_buf, 32'hCAFE_0040);
    chk("R2 maxlen", {21'b0, c_len}, 32'd8);
    chk("R6 out code", {30'b0, c_code}, 32'd0);
    chk("R6 out ctrl", c_ctrl, IOC | E3C | 32'd7);
    chk("R3 ioc cause", {30'b0, c_int}, 32'd1);
  endtask

  task automatic t_in_short;
    exec(A | SPD | E3C, mk_tok(11'h03F, 1'b0, 4'h1, 7'h02, 8'h69), 32'h100, 3'd0, 12'd10, 0, 0);
    chk("R6 in short code", {30'b0, c_code}, 32'd0);
    chk("R6 in short ctrl", c_ctrl, SPD | E3C | 32'd9);
    chk("R8 short cause", {30'b0, c_int}, 32'd2);
  endtask

  task automatic t_in_zero;
    exec(A | E3C, mk_tok(11'd7, 1'b0, 4'h1, 7'h02, 8'h69), 32'h100, 3'd0, 12'd0, 0, 0);
    chk("R6 zero-length ctrl", c_ctrl, E3C | 32'h7FF);
    chk("R8 no short cause without SPD", {30'b0, c_int}, 32'd0);
  endtask

  task automatic t_in_full_spd;
    exec(A | SPD, mk_tok(11'd7, 1'b0, 4'h1, 7'h02, 8'h69), 32'h100, 3'd0, 12'd8, 0, 0);
    chk("R8 full length no cause", {30'b0, c_int}, 32'd0);
    chk("R6 full length ctrl", c_ctrl, SPD | 32'd7);
  endtask

  task automatic t_out_spd;
    exec(A | SPD, mk_tok(11'd7, 1'b0, 4'h1, 7'h02, 8'hE1), 32'h100, 3'd0, 12'd2, 0, 0);
    chk("R8 OUT never short", {30'b0, c_int}, 32'd0);
  endtask

  task automatic t_babble;
    exec(A | E3C, mk_tok(11'd7, 1'b0, 4'h3, 7'h09, 8'h69), 32'h200, 3'd0, 12'd20, 0, 0);
    chk("R7 babble code", {30'b0, c_code}, 32'd1);
    chk("R7 babble ctrl", c_ctrl, E3C | BAB | STL | 32'd7);
  endtask

  task automatic t_wrap;
    exec(A | E3C, mk_tok(11'h7FF, 1'b0, 4'h0, 7'h00, 8'h2D), 32'h300, 3'd0, 12'd0, 0, 0);
    chk("R2 maxlen wrap", {21'b0, c_len}, 32'd0);
    chk("R6 setup ctrl", c_ctrl, E3C | 32'h7FF);
    chk("R6 setup code", {30'b0, c_code}, 32'd0);
  endtask

  task automatic t_inactive;
    exec(IOC | E3C | 32'h055, mk_tok(11'd7, 1'b0, 4'h0, 7'h00, 8'h00), 32'h0, 3'd0, 12'd0, 0, 0);
    chk("R4 no request", {31'b0, saw_req}, 32'd0);
    chk("R4 code", {30'b0, c_code}, 32'd1);
    chk("R4 ctrl kept", c_ctrl, IOC | E3C | 32'h055);
    chk("R4 no perr", {31'b0, saw_perr}, 32'd0);
    chk("R3 ioc on inactive", {30'b0, c_int}, 32'd1);
  endtask

  task automatic t_badpid;
    exec(A | E3C, mk_tok(11'd7, 1'b0, 4'h0, 7'h00, 8'h5A), 32'h0, 3'd0, 12'd0, 0, 0);
    chk("R5 code", {30'b0, c_code}, 32'd3);
    chk("R5 perr", {31'b0, saw_perr}, 32'd1);
    chk("R5 no request", {31'b0, saw_req}, 32'd0);
    chk("R5 ctrl kept", c_ctrl, A | E3C);
  endtask

  task automatic t_defer;
    exec(A | IOC | E3C | 32'h010, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'h69), 32'h0, 3'd4, 12'd3, 0, 0);
    chk("R9 code", {30'b0, c_code}, 32'd2);
    chk("R9 ctrl kept", c_ctrl, A | IOC | E3C | 32'h010);
  endtask

  task automatic t_nak_stall;
    exec(A | E2C, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'hE1), 32'h0, 3'd1, 12'd0, 0, 0);
    chk("R10 nak ctrl", c_ctrl, A | E2C | NAK);
    chk("R10 nak code", {30'b0, c_code}, 32'd1);
    exec(A | E3C, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'hE1), 32'h0, 3'd2, 12'd0, 0, 0);
    chk("R10 stall ctrl", c_ctrl, E3C | STL);
  endtask

  task automatic t_errors;
    exec(A | E2C, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'h69), 32'h0, 3'd3, 12'd0, 0, 0);
    chk("R11 count 2 to 1", c_ctrl, A | E1C | TMO);
    chk("R11 code", {30'b0, c_code}, 32'd1);
    exec(A | E1C, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'h69), 32'h0, 3'd3, 12'd0, 0, 0);
    chk("R11 count 1 to 0 stops", c_ctrl, TMO);
    exec(A, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'h69), 32'h0, 3'd7, 12'd0, 0, 0);
    chk("R11 count 0 unlimited", c_ctrl, A | TMO);
  endtask

  task automatic t_iso;
    exec(A | ISO | E3C, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'hE1), 32'h0, 3'd1, 12'd0, 0, 0);
    chk("R12 iso nak clears active", c_ctrl, ISO | E3C | NAK);
    exec(A | ISO | E3C, mk_tok(11'd7, 1'b0, 4'h0, 7'h01, 8'hE1), 32'h0, 3'd4, 12'd0, 0, 0);
    chk("R12 iso deferred kept", c_ctrl, A | ISO | E3C);
  endtask

  task automatic t_busy;
    exec(A | E3C, mk_tok(11'd3, 1'b0, 4'h2, 7'h11, 8'hE1), 32'h40, 3'd0, 12'd0, 5, 1);
    chk("R13 single result", npulse, 32'd1);
    chk("R13 first descriptor wins", c_ctrl, E3C | 32'd3);
    chk("R13 code", {30'b0, c_code}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_out_ok();
    t_in_short();
    t_in_zero();
    t_in_full_spd();
    t_out_spd();
    t_babble();
    t_wrap();
    t_inactive();
    t_badpid();
    t_defer();
    t_nak_stall();
    t_errors();
    t_iso();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R13 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule